// File: doc/BRIEF.md
# Debug Channel Character Mailbox

This block passes single characters between a processor and a host debug link. It holds two 32-bit words: an outgoing word, written by the processor and forwarded to the host, and an incoming word, filled by the host and drained by the processor. Each word keeps a character in bits 7:0. Bit 8 of the incoming word is a full flag, and it gates the host handshake.

On the processor side there is a plain register port. It has a write strobe, a read strobe, a 32-bit write data bus, a registered 32-bit read data bus and one select line per word. On the host side there are two streams. The outgoing stream is a valid/character pair. The incoming stream uses valid/ready: ready is high only while the incoming word is empty. The processor acknowledges a character by writing any value to the incoming word. Only the full flag changes on that write. There is no FIFO. One character is held at a time, and the host waits until it is taken. Both sides share one clock and one synchronous active-high reset.

Top module: `dbgmbx_top`

## Requirements
- R1: While reset is high, and at the first sample after it, both words read as zero, host_tx_valid is low, host_rx_ready is high and cpu_rdata is zero.
- R2: A processor write with cpu_sel_tx high stores all 32 bits of cpu_wdata in the outgoing word. A later read of that word returns the value unchanged.
- R3: Each outgoing write raises host_tx_valid for exactly the one clock after the write edge. In that clock host_tx_char equals bits 7:0 of the written data. Without such a write, host_tx_valid stays low.
- R4: host_rx_ready is high exactly when bit 8 (the full flag) of the incoming word is zero.
- R5: When host_rx_valid and host_rx_ready are both high at an edge, the incoming word becomes the received character in bits 7:0, with bit 8 set and all other bits zero.
- R6: When host_rx_valid is high while the full flag is set, the incoming word keeps its value, unless the processor clears it in the same cycle.
- R7: A processor write with cpu_sel_rx high clears bit 8 of the incoming word. All other bits keep their value, and the write data is ignored.
- R8: If a clearing write and an accepted host character fall on the same edge, the host character is stored and the full flag ends up set.
- R9: A read with cpu_rd_en high loads cpu_rdata at the next edge with the word value from before that edge. The outgoing word wins if both selects are high, and the result is zero if neither is. cpu_rdata holds its value when no read occurs. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_sel_tx | input | 1 | Selects the outgoing word |
| cpu_sel_rx | input | 1 | Selects the incoming word |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Registered processor read data |
| host_tx_valid | output | 1 | One-clock pulse per outgoing character |
| host_tx_char | output | 8 | Outgoing character |
| host_rx_valid | input | 1 | Host offers a character |
| host_rx_char | input | 8 | Incoming character |
| host_rx_ready | output | 1 | Incoming word is empty and can accept |

## Verification
The bench uses the default widths: a 32-bit word and an 8-bit character, so the full flag sits at bit 8. Random data drives all 32 bits, including bit 8 of the outgoing word and bits above the character in writes that clear the incoming word. This shows that the outgoing word keeps every bit, and that a clearing write leaves bits 7:0 and the zero upper bits alone. Host offers are frequent while the flag is set and clearing writes are sparse. That makes blocked offers, same-edge clear-and-accept cases and reads of a full word common.

// File: rtl/dbgmbx_pkg.sv
package dbgmbx_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned CHAR_W_DEF = 8;

  typedef enum logic [1:0] {
    RSRC_HOLD = 2'd0,
    RSRC_TX   = 2'd1,
    RSRC_RX   = 2'd2,
    RSRC_ZERO = 2'd3
  } rd_src_e;
endpackage

// File: rtl/dbgmbx_tx_reg.sv
module dbgmbx_tx_reg #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char
);
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [CHAR_W-1:0] char_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= wr_en;
      if (wr_en) begin
        word_q <= wdata;
        char_q <= wdata[CHAR_W-1:0];
      end
    end
  end

  assign word      = word_q;
  assign out_valid = valid_q;
  assign out_char  = char_q;

  // R3: one pulse per write, carrying the written character
  a_r3_pulse_on_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (out_valid && out_char == $past(wdata[CHAR_W-1:0])));
  a_r3_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !out_valid);
  // R2: the whole word is kept
  a_r2_word_stored: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> word == $past(wdata));
endmodule

// File: rtl/dbgmbx_rx_hold.sv
module dbgmbx_rx_hold #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              in_ready,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned FULL_POS = CHAR_W;
  localparam int unsigned PAD_W    = WORD_W - CHAR_W - 1;

  logic [WORD_W-1:0] word_q;
  logic              full;
  logic              accept;

  assign full     = word_q[FULL_POS];
  assign in_ready = ~full;
  assign accept   = in_valid & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= {{PAD_W{1'b0}}, 1'b1, in_char};
    end else if (clr_en) begin
      word_q[FULL_POS] <= 1'b0;
    end
  end

  assign word = word_q;

  // R5 / R8: an accepted character lands with the flag set, even over a clear
  a_r5_accept_stores: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (word[FULL_POS] && word[CHAR_W-1:0] == $past(in_char)));
  a_r4_ready_drops_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R6: offers while full leave the word untouched
  a_r6_blocked_offer: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !clr_en) |=> $stable(word));
  // R7: a clear keeps the character and drops only the flag
  a_r7_clear_only_flag: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(in_valid && in_ready)) |=>
      (!word[FULL_POS] && word[CHAR_W-1:0] == $past(word[CHAR_W-1:0])));
endmodule

// File: rtl/dbgmbx_rd_port.sv
module dbgmbx_rd_port
  import dbgmbx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              sel_tx,
  input  logic              sel_rx,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] rdata
);
  rd_src_e           src;
  logic [WORD_W-1:0] rdata_q;

  always_comb begin
    if (!rd_en)      src = RSRC_HOLD;
    else if (sel_tx) src = RSRC_TX;
    else if (sel_rx) src = RSRC_RX;
    else             src = RSRC_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (src)
        RSRC_HOLD: rdata_q <= rdata_q;
        RSRC_TX:   rdata_q <= tx_word;
        RSRC_RX:   rdata_q <= rx_word;
        RSRC_ZERO: rdata_q <= '0;
        default:   rdata_q <= rdata_q;
      endcase
    end
  end

  assign rdata = rdata_q;

  // R9: read data holds between reads
  a_r9_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/dbgmbx_top.sv
module dbgmbx_top
  import dbgmbx_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned CHAR_W = CHAR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic              cpu_sel_tx,
  input  logic              cpu_sel_rx,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              host_tx_valid,
  output logic [CHAR_W-1:0] host_tx_char,
  input  logic              host_rx_valid,
  input  logic [CHAR_W-1:0] host_rx_char,
  output logic              host_rx_ready
);
  logic [WORD_W-1:0] tx_word;
  logic [WORD_W-1:0] rx_word;
  logic              tx_wr;
  logic              rx_clr;

  assign tx_wr  = cpu_wr_en & cpu_sel_tx;
  assign rx_clr = cpu_wr_en & cpu_sel_rx;

  dbgmbx_tx_reg #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst), .wr_en(tx_wr), .wdata(cpu_wdata),
    .word(tx_word), .out_valid(host_tx_valid), .out_char(host_tx_char)
  );

  dbgmbx_rx_hold #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst(rst), .clr_en(rx_clr), .in_valid(host_rx_valid),
    .in_char(host_rx_char), .in_ready(host_rx_ready), .word(rx_word)
  );

  dbgmbx_rd_port #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(cpu_rd_en), .sel_tx(cpu_sel_tx),
    .sel_rx(cpu_sel_rx), .tx_word(tx_word), .rx_word(rx_word), .rdata(cpu_rdata)
  );

  // R1: clean state on the cycle after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!host_tx_valid && host_rx_ready && cpu_rdata == '0));
endmodule

// File: tb/dbgmbx_top_tb_top.sv
module dbgmbx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, rd_en, sel_tx, sel_rx;
  logic [WW-1:0] wdata, rdata;
  logic tx_valid, rx_valid, rx_ready;
  logic [CW-1:0] tx_char, rx_char;

  int n_cmp = 0;
  int n_bad = 0;

  logic [WW-1:0] m_tx, m_rx, m_rd;
  logic          m_txv;
  logic [CW-1:0] m_txc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgmbx_top dut_i (
    .clk(clk), .rst(rst), .cpu_wr_en(wr_en), .cpu_rd_en(rd_en),
    .cpu_sel_tx(sel_tx), .cpu_sel_rx(sel_rx), .cpu_wdata(wdata),
    .cpu_rdata(rdata), .host_tx_valid(tx_valid), .host_tx_char(tx_char),
    .host_rx_valid(rx_valid), .host_rx_char(rx_char), .host_rx_ready(rx_ready)
  );

  function automatic logic [WW-1:0] next_rx(logic [WW-1:0] cur, logic clr,
                                            logic v, logic [CW-1:0] c);
    logic [WW-1:0] r;
    r = cur;
    if (v && !cur[CW]) r = {{(WW-CW-1){1'b0}}, 1'b1, c};
    else if (clr)      r[CW] = 1'b0;
    return r;
  endfunction

  function automatic logic [WW-1:0] next_rd(logic [WW-1:0] cur, logic re,
                                            logic st, logic sr,
                                            logic [WW-1:0] t, logic [WW-1:0] x);
    if (!re) return cur;
    if (st)  return t;
    if (sr)  return x;
    return '0;
  endfunction

  task automatic check(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, advance the model, compare after the next falling edge
  task automatic cyc(logic we, logic re, logic st, logic sr, logic [WW-1:0] wd,
                     logic rv, logic [CW-1:0] rc, string tag);
    wr_en = we; rd_en = re; sel_tx = st; sel_rx = sr; wdata = wd;
    rx_valid = rv; rx_char = rc;
    #1;
    check({tag, " R4 ready"}, {31'b0, rx_ready}, {31'b0, ~m_rx[CW]});
    m_rd  = next_rd(m_rd, re, st, sr, m_tx, m_rx);
    m_txv = we && st;
    if (we && st) begin m_tx = wd; m_txc = wd[CW-1:0]; end
    m_rx  = next_rx(m_rx, we && sr, rv, rc);
    @(negedge clk);
    check({tag, " R3 txvalid"}, {31'b0, tx_valid}, {31'b0, m_txv});
    if (m_txv) check({tag, " R3 txchar"}, {24'b0, tx_char}, {24'b0, m_txc});
    check({tag, " R9 rdata"}, rdata, m_rd);
  endtask

  task automatic rd_word(logic st, string tag);
    cyc(1'b0, 1'b1, st, ~st, '0, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 0; rd_en = 0; sel_tx = 0; sel_rx = 0; wdata = '0;
    rx_valid = 0; rx_char = '0;
    m_tx = '0; m_rx = '0; m_rd = '0; m_txv = 0; m_txc = '0;
    repeat (3) @(negedge clk);
    check("R1 txvalid", {31'b0, tx_valid}, '0);
    check("R1 ready",   {31'b0, rx_ready}, 32'd1);
    check("R1 rdata",   rdata, '0);
    rst = 1'b0;
    rd_word(1'b1, "R1 tx word");
    check("R1 tx zero", rdata, '0);
    rd_word(1'b0, "R1 rx word");
    check("R1 rx zero", rdata, '0);

    // R2 / R3 directed: full word stored, char emitted once
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 32'hDEAD_B141, 1'b0, '0, "R2 wr");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R3 gap");
    rd_word(1'b1, "R2 rd");
    check("R2 readback", rdata, 32'hDEAD_B141);

    // R5 accept, R6 blocked offer, R9 read has no side effect
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 8'h5A, "R5 acc");
    check("R5 ready low", {31'b0, rx_ready}, '0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 8'hC3, "R6 blocked");
    rd_word(1'b0, "R6 rd");
    check("R6 word", rdata, 32'h0000_015A);
    rd_word(1'b0, "R9 rd again");
    check("R9 no side effect", rdata, 32'h0000_015A);

    // R7 clear only flag, data ignored
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, "R7 clr");
    rd_word(1'b0, "R7 rd");
    check("R7 word", rdata, 32'h0000_005A);

    // R8 coincidence: flag clear, clear write + offer same edge
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 1'b1, 8'h77, "R8 coinc");
    rd_word(1'b0, "R8 rd");
    check("R8 word", rdata, 32'h0000_0177);

    // R9: both selects -> outgoing word; none -> zero
    cyc(1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0, '0, "R9 both");
    check("R9 both", rdata, 32'hDEAD_B141);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R9 none");
    check("R9 none", rdata, '0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic we, re, st, sr, rv;
      we = ($urandom % 3) == 0;
      re = ($urandom % 2) == 0;
      st = ($urandom % 2) == 0;
      sr = ($urandom % 5) == 0;
      rv = ($urandom % 3) != 0;
      cyc(we, re, st, sr, $urandom, rv, 8'($urandom), "RND");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule